// File: doc/BRIEF.md
# PWM Auto-Shutdown Override Controller

This block stands between a complementary PWM waveform generator and its output drivers and decides when the waveform must be replaced by safe, programmed levels. It watches a group of external fault lines, each of which can be enabled or masked, together with a software shutdown request. When any enabled fault is live, or the shutdown status bit is set, it issues per-output override commands to the output stage. Each command either drives a fixed level, releases the pin to high impedance, or tells the stage to apply its inactive PWM level.

The live fault path reaches the override outputs without passing through a register, so a fault takes effect without waiting for a clock edge. In parallel, the fault lines are synchronised and latch a shutdown status bit that software can read back. The bit is cleared in one of two ways. Software can clear it. If auto-restart is enabled, the block clears it by itself on a rising-event strobe, provided no enabled fault remains.

Top module: `asd_override_ctrl`

## Requirements
- R1: The enabled fault inputs are ORed together, and only they can cause shutdown. A fault line whose bit in `fault_en_i` is 0 changes neither `sd_status_o` nor any override output.
- R2: While any fault line is 1 with its enable bit set, `sd_active_o` is 1 and the override commands are applied in the same cycle, with no clock edge required.
- R3: An enabled fault held steady is seen through a synchroniser of `SYNC_STAGES` flops (default 2). `sd_status_o` becomes 1 on rising edge number `SYNC_STAGES`+1 after the fault appears.
- R4: A cycle with `sw_set_i` = 1 sets `sd_status_o` at the next rising edge.
- R5: With `auto_restart_i` = 0, `sd_status_o` stays 1 through any number of rising-event strobes. It clears only at an edge where `sw_clr_i` = 1, no synchronised enabled fault is present, and `sw_set_i` = 0.
- R6: With `auto_restart_i` = 1, a cycle with `rise_evt_i` = 1 and no synchronised enabled fault clears `sd_status_o` at that edge.
- R7: With `auto_restart_i` = 1, a rising event while a synchronised enabled fault is still present leaves `sd_status_o` at 1.
- R8: A set condition (`sw_set_i` or a synchronised enabled fault) takes priority over any clear in the same cycle.
- R9: Each output `k` reads its own 2-bit field `ovr_sel_i[2k+1:2k]`. The codes are: 00 inactive PWM level (`ovr_inact_o[k]`=1); 01 high impedance (`ovr_hiz_o[k]`=1); 10 driven low (`ovr_drive_o[k]`=1, `ovr_level_o[k]`=0); 11 driven high (`ovr_drive_o[k]`=1, `ovr_level_o[k]`=1). During shutdown exactly one of drive, hiz and inact is 1 for each output.
- R10: While `sd_active_o` is 0, all four override outputs are 0 for every output.
- R11: After reset, `sd_status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | NUM_FAULTS | Raw fault lines, active high, may be asynchronous |
| fault_en_i | input | NUM_FAULTS | Per-line fault enable mask |
| sw_set_i | input | 1 | Software request to set the shutdown bit |
| sw_clr_i | input | 1 | Software request to clear the shutdown bit |
| auto_restart_i | input | 1 | Enables automatic release on a rising event |
| rise_evt_i | input | 1 | Rising-event strobe, one cycle per event |
| ovr_sel_i | input | 2*NUM_OUTS | Per-output override selection, 2 bits each |
| sd_status_o | output | 1 | Shutdown status readback |
| sd_active_o | output | 1 | Shutdown in force (status or live enabled fault) |
| ovr_drive_o | output | NUM_OUTS | Drive the pin at `ovr_level_o` |
| ovr_level_o | output | NUM_OUTS | Forced level when driving |
| ovr_hiz_o | output | NUM_OUTS | Release the pin to high impedance |
| ovr_inact_o | output | NUM_OUTS | Apply the inactive PWM level |

## Verification
The assertions assume that `rst_n` is low at start-up and that all control inputs other than the fault lines change away from the active clock edge. The checks on the status bit also assume that a fault line stays steady long enough to be synchronised. The bench drives every input, fault lines included, just after the falling edge, so the synchroniser always captures a settled value and the status latency is exact. The random phase toggles faults, enables, strobes and software requests at low rates. This keeps shutdown episodes long enough for both clear paths and the set-over-clear priority to occur many times.

// File: rtl/asd_pkg.sv
package asd_pkg;
  typedef enum logic [1:0] {
    OVR_INACT = 2'b00,
    OVR_HIZ   = 2'b01,
    OVR_LOW   = 2'b10,
    OVR_HIGH  = 2'b11
  } ovr_sel_e;

  localparam int unsigned OVR_SEL_W = 2;
endpackage

// File: rtl/asd_fault_sync.sv
module asd_fault_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb chain_d[s] = async_i;
    end else begin : g_next
      always_comb chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_d[s];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/asd_status.sv
module asd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic flt_hit_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic auto_restart_i,
  input  logic rise_evt_i,
  output logic status_o
);
  logic status_q, status_d;
  logic set_req, auto_rel, clr_req;

  always_comb begin
    set_req  = sw_set_i | flt_hit_i;
    auto_rel = auto_restart_i & rise_evt_i & ~flt_hit_i;
    clr_req  = sw_clr_i | auto_rel;
    status_d = status_q;
    if (set_req)      status_d = 1'b1;
    else if (clr_req) status_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  // R3 / R8: a synchronised fault always leaves the bit set
  assert_fault_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flt_hit_i |=> status_q);

  // R4: software set request always lands
  assert_sw_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_i |=> status_q);

  // R5 / R6: the bit only falls after a clear source
  assert_release_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_q) |-> $past(sw_clr_i | (auto_restart_i & rise_evt_i)));

  // R7: no automatic release while a fault remains
  assert_hold_with_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && flt_hit_i) |=> status_q);
endmodule

// File: rtl/asd_ovr_decode.sv
module asd_ovr_decode
  import asd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active_i,
  input  logic [OVR_SEL_W-1:0] sel_i,
  output logic                 drive_o,
  output logic                 level_o,
  output logic                 hiz_o,
  output logic                 inact_o
);
  ovr_sel_e sel;
  assign sel = ovr_sel_e'(sel_i);

  always_comb begin
    drive_o = 1'b0;
    level_o = 1'b0;
    hiz_o   = 1'b0;
    inact_o = 1'b0;
    if (active_i) begin
      unique case (sel)
        OVR_INACT: inact_o = 1'b1;
        OVR_HIZ:   hiz_o   = 1'b1;
        OVR_LOW:   drive_o = 1'b1;
        OVR_HIGH:  begin drive_o = 1'b1; level_o = 1'b1; end
        default:   inact_o = 1'b1;
      endcase
    end
  end

  // R9: at most one command kind per output
  assert_one_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_o, hiz_o, inact_o}));

  // R9: shutdown always produces a command
  assert_cmd_in_sd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (drive_o | hiz_o | inact_o));

  // R10: quiet when no shutdown
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |-> !(drive_o | level_o | hiz_o | inact_o));
endmodule

// File: rtl/asd_override_ctrl.sv
module asd_override_ctrl
  import asd_pkg::*;
#(
  parameter int unsigned NUM_FAULTS  = 4,
  parameter int unsigned NUM_OUTS    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_FAULTS-1:0]           fault_i,
  input  logic [NUM_FAULTS-1:0]           fault_en_i,
  input  logic                            sw_set_i,
  input  logic                            sw_clr_i,
  input  logic                            auto_restart_i,
  input  logic                            rise_evt_i,
  input  logic [OVR_SEL_W*NUM_OUTS-1:0]   ovr_sel_i,
  output logic                            sd_status_o,
  output logic                            sd_active_o,
  output logic [NUM_OUTS-1:0]             ovr_drive_o,
  output logic [NUM_OUTS-1:0]             ovr_level_o,
  output logic [NUM_OUTS-1:0]             ovr_hiz_o,
  output logic [NUM_OUTS-1:0]             ovr_inact_o
);
  logic [NUM_FAULTS-1:0] fault_sync;
  logic                  live_hit;
  logic                  sync_hit;
  logic                  status;

  asd_fault_sync #(
    .WIDTH (NUM_FAULTS),
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(fault_i),
    .sync_o (fault_sync)
  );

  assign live_hit = |(fault_i & fault_en_i);
  assign sync_hit = |(fault_sync & fault_en_i);

  asd_status status_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .flt_hit_i     (sync_hit),
    .sw_set_i      (sw_set_i),
    .sw_clr_i      (sw_clr_i),
    .auto_restart_i(auto_restart_i),
    .rise_evt_i    (rise_evt_i),
    .status_o      (status)
  );

  assign sd_status_o = status;
  assign sd_active_o = status | live_hit;

  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
    asd_ovr_decode dec_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .active_i(sd_active_o),
      .sel_i   (ovr_sel_i[OVR_SEL_W*k +: OVR_SEL_W]),
      .drive_o (ovr_drive_o[k]),
      .level_o (ovr_level_o[k]),
      .hiz_o   (ovr_hiz_o[k]),
      .inact_o (ovr_inact_o[k])
    );
  end

  // R1 / R2: a live enabled fault is always seen as shutdown at the outputs
  assert_live_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live_hit |-> (ovr_drive_o | ovr_hiz_o | ovr_inact_o) != '0);
endmodule

// File: tb/asd_override_ctrl_tb_top.sv
`timescale 1ns/1ps
module asd_override_ctrl_tb_top;
  localparam int NF = 4;
  localparam int NO = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NF-1:0] fault, fault_en;
  logic          sw_set, sw_clr, auto_rs, rise;
  logic [2*NO-1:0] sel;
  logic          st, act;
  logic [NO-1:0] drv, lvl, hiz, ina;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  asd_override_ctrl #(.NUM_FAULTS(NF), .NUM_OUTS(NO), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .fault_i(fault), .fault_en_i(fault_en),
    .sw_set_i(sw_set), .sw_clr_i(sw_clr), .auto_restart_i(auto_rs),
    .rise_evt_i(rise), .ovr_sel_i(sel), .sd_status_o(st), .sd_active_o(act),
    .ovr_drive_o(drv), .ovr_level_o(lvl), .ovr_hiz_o(hiz), .ovr_inact_o(ina)
  );

  // reference state from the requirements
  logic [NF-1:0] m_s1, m_s2;
  logic          m_st;

  function automatic logic next_status(logic cur, logic hit, logic s, logic c,
                                       logic a, logic r);
    if (s || hit) return 1'b1;
    if (c || (a && r && !hit)) return 1'b0;
    return cur;
  endfunction

  function automatic logic [3:0] exp_cmd(logic active, logic [1:0] code);
    if (!active) return 4'b0000;          // {drive, level, hiz, inact}
    case (code)
      2'b00:   return 4'b0001;
      2'b01:   return 4'b0010;
      2'b10:   return 4'b1000;
      default: return 4'b1100;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_st <= 1'b0;
    end else begin
      m_s1 <= fault;
      m_s2 <= m_s1;
      m_st <= next_status(m_st, |(m_s2 & fault_en), sw_set, sw_clr, auto_rs, rise);
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_model(string tag);
    logic a;
    a = m_st | (|(fault & fault_en));
    check({tag, " status"}, 32'(st), 32'(m_st));
    check({tag, " active"}, 32'(act), 32'(a));
    for (int k = 0; k < NO; k++)
      check({tag, " R9 command"}, 32'({drv[k], lvl[k], hiz[k], ina[k]}),
            32'(exp_cmd(a, sel[2*k +: 2])));
  endtask

  task automatic idle();
    fault = '0; sw_set = 0; sw_clr = 0; rise = 0;
  endtask

  // drive at negedge, look 1 ns later
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a5d));
    rst_n = 0; idle(); fault_en = '0; auto_rs = 0; sel = 4'b1101;
    repeat (3) step();
    rst_n = 1;
    step(); #1;
    // R11 / R10: reset state
    check("R11 status after reset", 32'(st), 0);
    check("R10 no override", 32'({drv, lvl, hiz, ina}), 0);

    // R1: a masked fault does nothing
    fault_en = 4'b1011; fault = 4'b0100;
    repeat (5) step(); #1;
    check("R1 masked fault status", 32'(st), 0);
    check("R1 masked fault active", 32'(act), 0);
    check("R1 masked fault outputs", 32'({drv, hiz, ina}), 0);

    // R2 / R3: enabled fault, immediate override, status on third edge
    step(); fault = 4'b0110; #1;
    check("R2 immediate active", 32'(act), 1);
    check("R2 immediate command out1 high", 32'({drv[1], lvl[1]}), 2'b11);
    check("R2 immediate command out0 hiz", 32'(hiz[0]), 1);
    step(); #1; check("R3 status after edge 1", 32'(st), 0);
    step(); #1; check("R3 status after edge 2", 32'(st), 0);
    step(); #1; check("R3 status after edge 3", 32'(st), 1);

    // R5: no auto-restart, rises do not clear
    fault = '0;
    repeat (4) step();
    for (int i = 0; i < 3; i++) begin
      step(); rise = 1; step(); rise = 0;
    end
    #1; check("R5 held through rises", 32'(st), 1);
    check("R5 active with no fault", 32'(act), 1);
    step(); sw_clr = 1; step(); sw_clr = 0; #1;
    check("R5 software clear", 32'(st), 0);
    check("R10 outputs released", 32'({drv, lvl, hiz, ina}), 0);

    // R4: software set
    step(); sw_set = 1; step(); sw_set = 0; #1;
    check("R4 software set", 32'(st), 1);

    // R7 / R6: auto-restart
    auto_rs = 1; fault = 4'b0001;
    repeat (3) step();
    rise = 1; step(); rise = 0; #1;
    check("R7 fault blocks release", 32'(st), 1);
    fault = '0;
    repeat (3) step();
    rise = 1; step(); rise = 0; #1;
    check("R6 auto release", 32'(st), 0);
    auto_rs = 0;

    // R8: set beats clear
    step(); sw_set = 1; sw_clr = 1; step(); idle(); #1;
    check("R8 set over clear", 32'(st), 1);

    // R9: every code on each output while in shutdown
    for (int c = 0; c < 16; c++) begin
      step(); sel = 4'(c); #1;
      for (int k = 0; k < NO; k++)
        check("R9 code table", 32'({drv[k], lvl[k], hiz[k], ina[k]}),
              32'(exp_cmd(1'b1, sel[2*k +: 2])));
    end
    step(); sw_clr = 1; step(); sw_clr = 0;

    // random phase checked against the reference state
    for (int n = 0; n < 3000; n++) begin
      step();
      if ($urandom_range(15) == 0) fault = fault ^ (4'b1 << $urandom_range(NF-1));
      if ($urandom_range(63) == 0) fault_en = 4'($urandom);
      if ($urandom_range(127) == 0) auto_rs = ~auto_rs;
      sw_set = ($urandom_range(40) == 0);
      sw_clr = ($urandom_range(12) == 0);
      rise   = ($urandom_range(5) == 0);
      if ($urandom_range(31) == 0) sel = 4'($urandom);
      #1;
      check_model("R1 R5 R6 R7 R8 random");
    end

    idle();
    step(); #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule